// File: doc/BRIEF.md
# Serial Register Access Port with Multi-Byte Streaming

This block is a slave for a four-wire or three-wire serial control bus. It gives a host access to a small byte-wide register file. Each access starts when the chip-select is asserted. The host then shifts in a 16-bit instruction: a direction bit, a two-bit length code and a 13-bit start address. One or more data bytes follow. Writes land in the register file. Reads are shifted back on the shared data line, or on a separate output line when the port is set to unidirectional operation.

Address 0 holds the port's own setup byte. Its upper and lower nibbles are mirror images, so it means the same thing whichever bit order it was shifted in. The byte selects the bit order and the read-data line. It takes effect at the next chip-select assertion.

The port runs on a fast system clock and oversamples the serial lines through a synchronizer. Each SCLK phase must therefore last at least four system-clock cycles. Addresses at or above the file depth are accepted on the bus but hold nothing.

Top module: `spi_regport`

## Requirements
- R1: The instruction is 16 bits, sent MSB first by default: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Length codes 2'b00, 2'b01 and 2'b10 move exactly 1, 2 and 3 bytes. Any further bits before chip-select is released are ignored and write nothing.
- R3: Length code 2'b11 keeps moving bytes, one after another, until chip-select is released.
- R4: In MSB-first order, data bytes are shifted MSB first and each successive byte uses the next lower address.
- R5: When setup bit 6 or bit 1 is set, the whole transfer runs LSB first. The instruction arrives address bit 0 first and the direction bit last, data bytes arrive LSB first, and each successive byte uses the next higher address.
- R6: Input bits are taken on rising SCLK edges. Read data changes only after a falling SCLK edge and holds steady across the following rising edge.
- R7: With setup bits 7 and 0 both clear, read data is driven on `sdio_out` with `sdio_oe` high. When setup bit 7 or bit 0 is set, read data goes to `sdo_out` with `sdo_oe` high and `sdio_oe` stays low. The two enables are never high together, and both are low while no read data is being shifted.
- R8: Address 0 is the setup byte. It reads back what was written, and a write to it first takes effect at the next chip-select assertion.
- R9: Releasing chip-select at any point ends the transfer, restarts bit counting and releases both data lines. A byte that has not received all 8 bits is never written.
- R10: Writes to addresses at or above the file depth have no effect, and reads from them return 8'h00.
- R11: After reset the setup byte is 8'h00 (MSB first, bidirectional) and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial shift clock from the host |
| sdio_in | input | 1 | Received level of the shared data line |
| sdio_out | output | 1 | Value driven onto the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line; low means released |
| sdo_out | output | 1 | Read data for the dedicated output line |
| sdo_oe | output | 1 | Drive enable for the dedicated output line |

## Verification
The bench builds the port with a file depth of 64 and a two-stage synchronizer. The small depth puts address 100 outside the file, so the dropped-write and zero-read path is reachable from ordinary transfers. It also keeps the storage small while streaming runs across several neighbouring addresses. The two-stage synchronizer adds latency to each edge, and the bench's half-period of ten system cycles sits well clear of it. This lets the bench check that read data holds across the rising edge and that the data-line handover follows each mode change made through the setup byte.

// File: rtl/spi_regport_pkg.sv
`timescale 1ns/1ps
package spi_regport_pkg;
  localparam int HDR_BITS  = 16;
  localparam int ADDR_BITS = 13;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(HDR_BITS);

  localparam logic [1:0] LEN_STREAM = 2'b11;

  typedef enum logic [1:0] {
    PH_HEADER,
    PH_DATA,
    PH_IDLE
  } phase_e;

  typedef struct packed {
    logic                 rd;
    logic [1:0]           len;
    logic [ADDR_BITS-1:0] addr;
  } instr_t;
endpackage

// File: rtl/spi_regport_sync.sv
`timescale 1ns/1ps
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic sel,
  output logic sel_start,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;
  localparam logic [2:0] IDLE_VEC = 3'b100;

  logic [STAGES-1:0][2:0] pipe;
  logic [2:0]             in_vec;
  logic                   sel_d;
  logic                   sck_d;

  assign in_vec = {cs_n, sclk, mosi};

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) pipe <= IDLE_VEC;
      else     pipe <= in_vec;
    end
  end else begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{IDLE_VEC}};
      else     pipe <= {pipe[STAGES-2:0], in_vec};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      sel_d <= ~pipe[LAST][2];
      sck_d <= pipe[LAST][1];
    end
  end

  assign sel       = ~pipe[LAST][2];
  assign sel_start = sel & ~sel_d;
  assign sck_rise  = pipe[LAST][1] & ~sck_d;
  assign sck_fall  = ~pipe[LAST][1] & sck_d;
  assign mosi_s    = pipe[LAST][0];
endmodule

// File: rtl/spi_regport_engine.sv
`timescale 1ns/1ps
module spi_regport_engine
  import spi_regport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 sel_start,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 din,
  input  logic                 cfg_lsb,
  input  logic                 cfg_uni,
  input  logic [7:0]           rd_data,
  output logic                 wr_en,
  output logic                 rd_en,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           wr_data,
  output logic                 dout,
  output logic                 dio_oe,
  output logic                 do_oe
);
  phase_e               phase;
  logic [CNT_W-1:0]     bit_cnt;
  logic [HDR_BITS-1:0]  shreg;
  logic                 rd_q;
  logic [1:0]           len_q;
  logic [ADDR_BITS-1:0] cur_addr;
  logic [1:0]           byte_idx;
  logic                 lsb_q;
  logic                 uni_q;
  logic [7:0]           tx;
  logic                 pend1;
  logic                 pend2;

  logic                 lsb_now;
  logic [HDR_BITS-1:0]  shreg_next;
  logic [7:0]           byte_next;
  instr_t               instr_next;
  logic [ADDR_BITS-1:0] addr_step;
  logic                 last_byte;

  always_comb begin
    lsb_now    = sel_start ? cfg_lsb : lsb_q;
    shreg_next = lsb_now ? {din, shreg[HDR_BITS-1:1]} : {shreg[HDR_BITS-2:0], din};
    byte_next  = lsb_now ? {din, shreg[7:1]} : {shreg[6:0], din};
    instr_next = instr_t'(shreg_next);
    addr_step  = lsb_q ? cur_addr + 13'd1 : cur_addr - 13'd1;
    last_byte  = (len_q != LEN_STREAM) && (byte_idx == len_q);
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase    <= PH_HEADER;
      bit_cnt  <= '0;
      shreg    <= '0;
      wr_en    <= 1'b0;
      rd_en    <= 1'b0;
      pend1    <= 1'b0;
      pend2    <= 1'b0;
      dio_oe   <= 1'b0;
      do_oe    <= 1'b0;
      if (rst) begin
        rd_q     <= 1'b0;
        len_q    <= '0;
        cur_addr <= '0;
        byte_idx <= '0;
        lsb_q    <= 1'b0;
        uni_q    <= 1'b0;
        tx       <= '0;
        mem_addr <= '0;
        wr_data  <= '0;
        dout     <= 1'b0;
      end
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      pend1 <= 1'b0;
      pend2 <= pend1;
      if (sel_start) begin
        lsb_q <= cfg_lsb;
        uni_q <= cfg_uni;
      end
      if (pend2) tx <= rd_data;

      if (sck_rise) begin
        case (phase)
          PH_HEADER: begin
            shreg <= shreg_next;
            if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
              bit_cnt  <= '0;
              phase    <= PH_DATA;
              rd_q     <= instr_next.rd;
              len_q    <= instr_next.len;
              cur_addr <= instr_next.addr;
              byte_idx <= '0;
              if (instr_next.rd) begin
                rd_en    <= 1'b1;
                pend1    <= 1'b1;
                mem_addr <= instr_next.addr;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            shreg[7:0] <= byte_next;
            if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
              bit_cnt  <= '0;
              cur_addr <= addr_step;
              byte_idx <= byte_idx + 2'd1;
              if (!rd_q) begin
                wr_en    <= 1'b1;
                wr_data  <= byte_next;
                mem_addr <= cur_addr;
              end
              if (last_byte) begin
                phase <= PH_IDLE;
              end else if (rd_q) begin
                rd_en    <= 1'b1;
                pend1    <= 1'b1;
                mem_addr <= addr_step;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (phase == PH_DATA && rd_q) begin
        if (sck_fall) begin
          dout   <= lsb_q ? tx[0] : tx[7];
          tx     <= lsb_q ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
          dio_oe <= ~uni_q;
          do_oe  <= uni_q;
        end
      end else begin
        dio_oe <= 1'b0;
        do_oe  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_regport_bank.sv
`timescale 1ns/1ps
module spi_regport_bank
  import spi_regport_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  output logic [7:0]           cfg
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic             in_range;
  logic             is_cfg;
  logic [IDX_W-1:0] idx;

  assign in_range = int'(addr) < DEPTH;
  assign is_cfg   = (addr == '0);
  assign idx      = addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      cfg     <= '0;
    end else begin
      if (wr_en && is_cfg) cfg <= wr_data;
      if (rd_en) begin
        if (!in_range)   rd_data <= '0;
        else if (is_cfg) rd_data <= cfg;
        else             rd_data <= mem[idx];
      end
    end
  end
endmodule

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo_out,
  output logic sdo_oe
);
  logic                 sel;
  logic                 sel_start;
  logic                 sck_rise;
  logic                 sck_fall;
  logic                 din;
  logic                 wr_en;
  logic                 rd_en;
  logic [ADDR_BITS-1:0] mem_addr;
  logic [7:0]           wr_data;
  logic [7:0]           rd_data;
  logic [7:0]           cfg;
  logic                 cfg_lsb;
  logic                 cfg_uni;
  logic                 dout;

  // the setup nibbles mirror each other: 7<->0 and 6<->1
  assign cfg_uni = cfg[7] | cfg[0];
  assign cfg_lsb = cfg[6] | cfg[1];

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(sdio_in),
    .sel(sel), .sel_start(sel_start), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(din)
  );

  spi_regport_engine u_engine (
    .clk(clk), .rst(rst), .sel(sel), .sel_start(sel_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din),
    .cfg_lsb(cfg_lsb), .cfg_uni(cfg_uni), .rd_data(rd_data),
    .wr_en(wr_en), .rd_en(rd_en), .mem_addr(mem_addr), .wr_data(wr_data),
    .dout(dout), .dio_oe(sdio_oe), .do_oe(sdo_oe)
  );

  spi_regport_bank #(.DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(mem_addr),
    .wr_data(wr_data), .rd_data(rd_data), .cfg(cfg)
  );

  assign sdio_out = dout;
  assign sdo_out  = dout;
endmodule

// File: rtl/spi_regport_chk.sv
`timescale 1ns/1ps
module spi_regport_chk (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic sck_rise,
  input logic sck_fall,
  input logic wr_en,
  input logic sdio_out,
  input logic sdio_oe,
  input logic sdo_oe
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe)); // R7

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!sdio_oe && !sdo_oe)); // R9

  AST_WRITE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sck_rise)); // R6

  AST_OUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (sdio_out != $past(sdio_out)) |-> $past(sck_fall)); // R6

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sdio_oe && !sdo_oe)); // R11
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall),
  .wr_en(wr_en), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe)
);

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb;
  localparam int HALF = 10;
  localparam int NVEC = 11;

  typedef struct packed {
    logic        rd;
    logic [1:0]  len;
    logic [12:0] addr;
    logic [2:0]  nbytes;
    logic [31:0] data;
  } vec_t;

  // MSB-first, bidirectional; first byte in data[31:24]
  localparam vec_t VEC [NVEC] = '{
    {1'b0, 2'd2, 13'd10,  3'd3, 32'hA1B2C300},  // R2 three bytes, R4 descending
    {1'b1, 2'd2, 13'd10,  3'd3, 32'hA1B2C300},
    {1'b1, 2'd0, 13'd8,   3'd1, 32'hC3000000},
    {1'b0, 2'd1, 13'd12,  3'd2, 32'h44660000},
    {1'b0, 2'd0, 13'd12,  3'd2, 32'h5C770000},  // R2 second byte must be dropped
    {1'b1, 2'd1, 13'd12,  3'd2, 32'h5C660000},
    {1'b0, 2'd3, 13'd40,  3'd4, 32'h01020304},  // R3 stream
    {1'b1, 2'd3, 13'd39,  3'd3, 32'h02030400},
    {1'b0, 2'd0, 13'd100, 3'd1, 32'hEE000000},  // R10 out of range
    {1'b1, 2'd0, 13'd100, 3'd1, 32'h00000000},
    {1'b1, 2'd0, 13'd0,   3'd1, 32'h00000000}   // R11 setup reset value
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  spi_regport #(.DEPTH(64), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, input bit reading, input bit uni,
                           output logic r, inout bit lines_ok, inout bit stable_ok);
    sclk = 1'b0;
    sdio_in = b;
    repeat (HALF) @(negedge clk);
    r = uni ? sdo_out : sdio_out;
    if (reading) begin
      if (uni ? !(sdo_oe && !sdio_oe) : !(sdio_oe && !sdo_oe)) lines_ok = 1'b0;
    end else if (sdio_oe || sdo_oe) begin
      lines_ok = 1'b0;
    end
    sclk = 1'b1;
    repeat (HALF - 2) @(negedge clk);
    if (reading && ((uni ? sdo_out : sdio_out) !== r)) stable_ok = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input bit lsb, input bit uni, input logic rd, input logic [1:0] len,
                      input logic [12:0] a, input int nbytes, input logic [31:0] data,
                      input int stop_bits, output logic [31:0] got,
                      output bit lines_ok, output bit stable_ok);
    logic [15:0] hdr;
    logic [7:0]  tbyte;
    logic [7:0]  rbyte;
    logic        r;
    int          sent;
    hdr = {rd, len, a};
    got = '0;
    lines_ok = 1'b1;
    stable_ok = 1'b1;
    sent = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      bit_cycle(lsb ? hdr[i] : hdr[15-i], 1'b0, uni, r, lines_ok, stable_ok);
    end
    for (int k = 0; k < nbytes; k++) begin
      tbyte = data[31-8*k -: 8];
      rbyte = '0;
      for (int j = 0; j < 8; j++) begin
        if (stop_bits < 0 || sent < stop_bits) begin
          bit_cycle(lsb ? tbyte[j] : tbyte[7-j], rd, uni, r, lines_ok, stable_ok);
          rbyte[lsb ? j : 7-j] = r;
          sent++;
        end
      end
      got[31-8*k -: 8] = rbyte;
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      1:       return "R1 R4 descending read";
      2:       return "R4 single byte at lowest address";
      5:       return "R2 length limit";
      7:       return "R3 streamed read";
      9:       return "R10 out-of-range read";
      10:      return "R11 setup after reset";
      default: return "R1 transfer";
    endcase
  endfunction

  initial begin
    logic [31:0] got;
    bit lok, sok;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sdio_oe && !sdo_oe, "R11 enables low after reset", {30'd0, sdio_oe, sdo_oe}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      xfer(1'b0, 1'b0, VEC[i].rd, VEC[i].len, VEC[i].addr, int'(VEC[i].nbytes),
           VEC[i].data, -1, got, lok, sok);
      if (VEC[i].rd) begin
        chk(got === VEC[i].data, vec_tag(i), got, VEC[i].data);
        chk(sok, "R6 read bit held over rising edge", {31'd0, sok}, 32'd1);
      end
      chk(lok, "R7 data line ownership", {31'd0, lok}, 32'd1);
    end

    // R9: aborted write leaves the old value
    xfer(1'b0, 1'b0, 1'b0, 2'd0, 13'd5, 1, 32'h5A000000, -1, got, lok, sok);
    xfer(1'b0, 1'b0, 1'b0, 2'd0, 13'd5, 1, 32'hFF000000, 4, got, lok, sok);
    xfer(1'b0, 1'b0, 1'b1, 2'd0, 13'd5, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'h5A000000, "R9 partial byte not written", got, 32'h5A000000);

    // R9: aborted read releases the line
    xfer(1'b0, 1'b0, 1'b1, 2'd0, 13'd10, 1, 32'h0, 3, got, lok, sok);
    chk(!sdio_oe && !sdo_oe, "R9 lines released after abort", {30'd0, sdio_oe, sdo_oe}, 32'd0);

    // R5 / R8: switch to LSB-first
    xfer(1'b0, 1'b0, 1'b0, 2'd0, 13'd0, 1, 32'h42000000, -1, got, lok, sok);
    xfer(1'b1, 1'b0, 1'b0, 2'd1, 13'd30, 2, 32'h9D3E0000, -1, got, lok, sok);
    xfer(1'b1, 1'b0, 1'b1, 2'd1, 13'd30, 2, 32'h0, -1, got, lok, sok);
    chk(got === 32'h9D3E0000, "R5 LSB-first two-byte read", got, 32'h9D3E0000);
    xfer(1'b1, 1'b0, 1'b1, 2'd0, 13'd31, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'h3E000000, "R5 ascending address", got, 32'h3E000000);
    xfer(1'b1, 1'b0, 1'b1, 2'd0, 13'd0, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'h42000000, "R8 setup readback", got, 32'h42000000);

    // R7: unidirectional via 0x81 (same in either order)
    xfer(1'b1, 1'b0, 1'b0, 2'd0, 13'd0, 1, 32'h81000000, -1, got, lok, sok);
    xfer(1'b0, 1'b1, 1'b1, 2'd0, 13'd10, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'hA1000000, "R7 read on dedicated line", got, 32'hA1000000);
    chk(lok, "R7 shared line released in unidirectional mode", {31'd0, lok}, 32'd1);
    xfer(1'b0, 1'b1, 1'b1, 2'd0, 13'd0, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'h81000000, "R8 setup readback unidirectional", got, 32'h81000000);

    // R8: mirror bit 0 alone selects the dedicated line
    xfer(1'b0, 1'b1, 1'b0, 2'd0, 13'd0, 1, 32'h01000000, -1, got, lok, sok);
    xfer(1'b0, 1'b1, 1'b1, 2'd0, 13'd10, 1, 32'h0, -1, got, lok, sok);
    chk(got === 32'hA1000000 && lok, "R8 mirrored bit honoured", got, 32'hA1000000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule